// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the target-side answer to the shared-interrupt query on a two-wire SMBus. Several targets can pull one open-drain alert line low together. The host then reads from the alert response address to find out which target raised it. The block oversamples SCL and SDA with its system clock and detects START and STOP. It collects the first byte after START. It acknowledges only the read form of the alert response address (byte value 0x19). It then shifts out a response byte, most significant bit first, through an open-drain enable. Bitwise wired-AND arbitration runs on every bit, so the lowest byte on the bus wins. A target that loses falls silent until the next START or STOP.

The response byte is the device's own 8-bit address when its first alert pin is being driven low (`alert_low_i`). The alert is eligible whatever the pin polarity or forcing mode that caused it. Otherwise the response byte is 0x19. When the response byte leaves without loss and the device was eligible, `won_o` pulses for one clock, and the surrounding logic uses it to clear the alert. If the host acknowledges the response byte, a CRC-8 PEC byte follows; the parameter `PEC_EN` selects this.

The control is a state machine with these states:
- ST_IDLE: the bus is free.
- ST_ADDR: the address bits are being received.
- ST_ACK: the address byte is acknowledged.
- ST_TX: a byte is shifted out.
- ST_HACK: the host acknowledge is sampled.
- ST_PEC: the PEC byte is loaded.
- ST_WAIT_STOP: the device is silent.

Transitions:
- START enters ST_ADDR from any state.
- STOP enters ST_IDLE from any state.
- ST_ADDR goes to ST_ACK on a match and to ST_WAIT_STOP otherwise.
- ST_ACK goes to ST_TX on the SCL fall that ends the ninth clock.
- ST_TX goes to ST_WAIT_STOP on arbitration loss, and to ST_HACK after eight bits.
- ST_HACK goes to ST_PEC when the host acknowledges the response byte and PEC is enabled, and to ST_WAIT_STOP otherwise.
- ST_PEC goes to ST_TX on the next SCL fall.

Top module: `ara_responder`

## Requirements
- R1: A falling SDA while SCL is high (START) always restarts address reception, including a repeated START. A rising SDA while SCL is high (STOP) always returns to idle with SDA released.
- R2: The device drives SDA low in the ninth clock only when the received address byte is 0x19. For any other byte it drives nothing until the next START or STOP.
- R3: With `alert_low_i` high when the ninth clock ends, the device sends `dev_addr_i` MSB first. It changes its SDA drive only while SCL is low.
- R4: With `alert_low_i` low, the device sends the byte 0x19 in the same way.
- R5: If the device releases SDA for a 1 and samples SDA low while SCL is high, it releases SDA for the rest of the frame and sends neither the remaining bits nor a PEC.
- R6: With several devices on the bus, the host reads the smallest of their response bytes.
- R7: `won_o` is a one-clock pulse after the eighth response bit is sent without loss, and only for an eligible device. Once the winner's alert is cleared, a new query returns the smallest remaining response byte.
- R8: With `PEC_EN`=1, when the host acknowledges the response byte, the device sends a CRC-8 MSB first. The CRC uses polynomial 0x07, initial value 0x00 and no final XOR, and runs over 0x19 then the response byte.
- R9: When the host does not acknowledge the response byte, no PEC byte is driven.
- R10: After reset SDA is released and `won_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus SCL level |
| sda_i | input | 1 | Bus SDA level (wired-AND result) |
| dev_addr_i | input | 8 | Own 8-bit device address byte |
| alert_low_i | input | 1 | High while this device pulls its first alert pin low |
| sda_oe_o | output | 1 | High to pull SDA low |
| won_o | output | 1 | One-clock pulse when an eligible response wins |

## Verification
Two responders share one wired-AND bus. The bench sweeps address pairs and alert combinations and computes the winning byte and its CRC arithmetically. A responder that ignored a loss would corrupt the remaining bits or the PEC. A responder that pulsed `won_o` after losing would make the alert-clearing sequence return the wrong address. All 255 non-matching address bytes, including the write form 0x18, are sent to confirm that neither device acknowledges or drives; a loose comparator would show up as a pulled-low ninth bit. A repeated START after a rejected address must still be accepted, and a host NACK must leave the following byte at 0xFF; a device that kept shifting would appear there as a PEC.

// File: rtl/ara_pkg.sv
package ara_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_TX,
        ST_HACK,
        ST_PEC,
        ST_WAIT_STOP
    } ara_state_e;

    // Byte-wide CRC-8 update, MSB-first, no reflection.
    function automatic logic [BYTE_W-1:0] crc8_byte(
        input logic [BYTE_W-1:0] crc_in,
        input logic [BYTE_W-1:0] data,
        input logic [BYTE_W-1:0] poly
    );
        logic [BYTE_W-1:0] c;
        c = crc_in ^ data;
        for (int i = 0; i < BYTE_W; i++) begin
            c = c[BYTE_W-1] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/ara_bus_cond.sv
module ara_bus_cond #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_LEN-1:0] scl_chain;
    logic [SYNC_LEN-1:0] sda_chain;
    logic                scl_p;
    logic                sda_p;

    // Idle bus is high on both lines, so all stages reset to one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_p     <= 1'b1;
            sda_p     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_LEN-2:0], scl_i};
            sda_chain <= {sda_chain[SYNC_LEN-2:0], sda_i};
            scl_p     <= scl_chain[SYNC_LEN-1];
            sda_p     <= sda_chain[SYNC_LEN-1];
        end
    end

    assign scl_s     = scl_chain[SYNC_LEN-1];
    assign sda_s     = sda_chain[SYNC_LEN-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/ara_shreg.sv
module ara_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], sin};
        end
    end

endmodule

// File: rtl/ara_responder.sv
module ara_responder
    import ara_pkg::*;
#(
    parameter int                SYNC_LEN   = 2,
    parameter logic [BYTE_W-1:0] QUERY_BYTE = 8'h19,
    parameter logic [BYTE_W-1:0] IDLE_REPLY = 8'h19,
    parameter logic [BYTE_W-1:0] CRC_POLY   = 8'h07,
    parameter bit                PEC_EN     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [BYTE_W-1:0] dev_addr_i,
    input  logic              alert_low_i,
    output logic              sda_oe_o,
    output logic              won_o
);

    localparam int                CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    ara_bus_cond #(.SYNC_LEN(SYNC_LEN)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    ara_state_e        st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              is_pec, is_pec_n;
    logic              elig_q, elig_n;
    logic [BYTE_W-1:0] resp_q, resp_n;
    logic              oe_n, won_n;
    logic              sh_load, sh_shift;
    logic [BYTE_W-1:0] sh_val, sh_q;
    logic [BYTE_W-1:0] pec_val;
    logic [BYTE_W-1:0] pick_byte;

    ara_shreg #(.W(BYTE_W)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (sh_val),
        .shift    (sh_shift),
        .sin      (sda_s),
        .q        (sh_q)
    );

    generate
        if (PEC_EN) begin : g_pec
            assign pec_val = crc8_byte(crc8_byte('0, QUERY_BYTE, CRC_POLY), resp_q, CRC_POLY);
        end else begin : g_nopec
            assign pec_val = '0;
        end
    endgenerate

    assign pick_byte = alert_low_i ? dev_addr_i : IDLE_REPLY;

    // Next-state and next-output decode
    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        is_pec_n = is_pec;
        elig_n   = elig_q;
        resp_n   = resp_q;
        oe_n     = sda_oe_o;
        won_n    = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        sh_val   = '0;
        if (start_det) begin
            st_n     = ST_ADDR;
            cnt_n    = '0;
            is_pec_n = 1'b0;
            oe_n     = 1'b0;
        end else if (stop_det) begin
            st_n = ST_IDLE;
            oe_n = 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    oe_n = 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh_shift = 1'b1;
                        if (cnt == LAST_BIT) begin
                            cnt_n = '0;
                            st_n  = ({sh_q[BYTE_W-2:0], sda_s} == QUERY_BYTE) ? ST_ACK : ST_WAIT_STOP;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!sda_oe_o) begin
                            oe_n = 1'b1;
                        end else begin
                            elig_n  = alert_low_i;
                            resp_n  = pick_byte;
                            sh_load = 1'b1;
                            sh_val  = pick_byte;
                            oe_n    = ~pick_byte[BYTE_W-1];
                            cnt_n   = '0;
                            st_n    = ST_TX;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        if (!sda_oe_o && !sda_s) begin
                            st_n = ST_WAIT_STOP;
                            oe_n = 1'b0;
                        end else if (cnt == LAST_BIT) begin
                            cnt_n = '0;
                            st_n  = ST_HACK;
                            won_n = elig_q & ~is_pec;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end else if (scl_fall) begin
                        sh_shift = 1'b1;
                        oe_n     = ~sh_q[BYTE_W-2];
                    end
                end
                ST_HACK: begin
                    if (scl_fall) begin
                        oe_n = 1'b0;
                    end else if (scl_rise) begin
                        st_n = (!sda_s && PEC_EN && !is_pec) ? ST_PEC : ST_WAIT_STOP;
                    end
                end
                ST_PEC: begin
                    if (scl_fall) begin
                        sh_load  = 1'b1;
                        sh_val   = pec_val;
                        oe_n     = ~pec_val[BYTE_W-1];
                        is_pec_n = 1'b1;
                        cnt_n    = '0;
                        st_n     = ST_TX;
                    end
                end
                ST_WAIT_STOP: begin
                    oe_n = 1'b0;
                end
                default: begin
                    st_n = ST_IDLE;
                    oe_n = 1'b0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            is_pec <= 1'b0;
            elig_q <= 1'b0;
            resp_q <= '0;
        end else begin
            st     <= st_n;
            cnt    <= cnt_n;
            is_pec <= is_pec_n;
            elig_q <= elig_n;
            resp_q <= resp_n;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_o <= 1'b0;
            won_o    <= 1'b0;
        end else begin
            sda_oe_o <= oe_n;
            won_o    <= won_n;
        end
    end

    // R10: no drive while the bus is free
    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe_o);

    // R3: drive only changes while the synchronised SCL is low
    p_drive_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe_o));

    // R5: a device that has dropped out never pulls SDA
    p_silent_after_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_STOP) |-> !sda_oe_o);

    // R7: a win is reported only for an eligible device
    p_won_eligible_r7: assert property (@(posedge clk) disable iff (!rst_n)
        won_o |-> elig_q);

    // R7: the win indication is a single-cycle pulse
    p_won_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        won_o |=> !won_o);

    // R2: acknowledge drive is only entered through a matched address
    p_ack_after_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACK && $past(st) != ST_ACK) |-> $past(st) == ST_ADDR);

endmodule

// File: tb/ara_responder_tb_top.sv
module ara_responder_tb_top;

    localparam int H = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_scl = 1'b1;
    logic       host_sda = 1'b1;
    logic [7:0] addr_a = 8'h00, addr_b = 8'h00;
    logic       alert_a = 1'b0, alert_b = 1'b0;
    logic       oe_a, oe_b, won_a, won_b;
    wire        sda_bus = host_sda & ~oe_a & ~oe_b;

    int n_chk = 0;
    int n_fail = 0;
    int won_cnt_a = 0;
    int won_cnt_b = 0;

    always #5 clk = ~clk;

    ara_responder dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
        .dev_addr_i(addr_a), .alert_low_i(alert_a),
        .sda_oe_o(oe_a), .won_o(won_a)
    );

    ara_responder dut_b (
        .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus),
        .dev_addr_i(addr_b), .alert_low_i(alert_b),
        .sda_oe_o(oe_b), .won_o(won_b)
    );

    always @(posedge clk) begin
        if (won_a) won_cnt_a <= won_cnt_a + 1;
        if (won_b) won_cnt_b <= won_cnt_b + 1;
    end

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic bus_start();
        @(negedge clk);
        host_sda = 1'b1; half();
        host_scl = 1'b1; half();
        host_sda = 1'b0; half();
        host_scl = 1'b0;
    endtask

    task automatic bus_stop();
        @(negedge clk);
        host_sda = 1'b0; half();
        host_scl = 1'b1; half();
        host_sda = 1'b1; half();
    endtask

    task automatic clk_bit(input logic b, output logic r);
        @(negedge clk);
        host_sda = b;
        half();
        host_scl = 1'b1;
        repeat (H / 2) @(negedge clk);
        r = sda_bus;
        repeat (H / 2) @(negedge clk);
        host_scl = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] v, output logic acked);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
        clk_bit(1'b1, r);
        acked = ~r;
    endtask

    task automatic read_byte(input logic do_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            v[i] = r;
        end
        clk_bit(~do_ack, r);
    endtask

    function automatic logic [7:0] ref_crc(input logic [7:0] b0, input logic [7:0] b1);
        logic [15:0] stream;
        logic [7:0]  c;
        logic        fb;
        stream = {b0, b1};
        c = 8'h00;
        for (int i = 15; i >= 0; i--) begin
            fb = c[7] ^ stream[i];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    function automatic logic [7:0] exp_resp();
        logic [7:0] ra, rb;
        ra = alert_a ? addr_a : 8'h19;
        rb = alert_b ? addr_b : 8'h19;
        return (ra < rb) ? ra : rb;
    endfunction

    // Full query with host ACK on the response byte, NACK on the PEC
    task automatic query(output logic acked, output logic [7:0] resp, output logic [7:0] pec);
        bus_start();
        write_byte(8'h19, acked);
        read_byte(1'b1, resp);
        read_byte(1'b0, pec);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %h expected %h", 8'h01, 8'h00);
        summary();
    end

    initial begin
        logic       acked;
        logic [7:0] resp, pec, er, other;
        int         wa0, wb0;
        logic [7:0] alist [4];
        logic [7:0] blist [4];
        alist[0] = 8'h02; alist[1] = 8'h12; alist[2] = 8'h30; alist[3] = 8'hA4;
        blist[0] = 8'h04; blist[1] = 8'h10; blist[2] = 8'h22; blist[3] = 8'hFE;

        repeat (5) @(negedge clk);
        // R10: reset state
        check(oe_a == 1'b0 && oe_b == 1'b0, "R10 sda released in reset", {7'd0, oe_a | oe_b}, 8'h00);
        check(won_a == 1'b0, "R10 won low in reset", {7'd0, won_a}, 8'h00);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_bus == 1'b1, "R10 bus high after reset", {7'd0, sda_bus}, 8'h01);

        // R2: every non-matching address byte is ignored
        alert_a = 1'b1; alert_b = 1'b1; addr_a = 8'h02; addr_b = 8'h04;
        for (int v = 0; v < 256; v++) begin
            if (v != 8'h19) begin
                bus_start();
                write_byte(8'(v), acked);
                check(!acked, "R2 no ack for other address", {7'd0, acked}, 8'h00);
                read_byte(1'b0, resp);
                check(resp == 8'hFF, "R2 no drive after other address", resp, 8'hFF);
                bus_stop();
            end
        end
        check(won_cnt_a == 0 && won_cnt_b == 0, "R7 no win without query", 8'(won_cnt_a + won_cnt_b), 8'h00);

        // R3 R4 R5 R6 R7 R8: pair and alert sweep
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                for (int m = 0; m < 4; m++) begin
                    addr_a = alist[i]; addr_b = blist[j];
                    alert_a = m[0]; alert_b = m[1];
                    er = exp_resp();
                    wa0 = won_cnt_a; wb0 = won_cnt_b;
                    query(acked, resp, pec);
                    check(acked, "R2 query acknowledged", {7'd0, acked}, 8'h01);
                    check(resp == er, "R3 R4 R6 lowest response byte", resp, er);
                    check(pec == ref_crc(8'h19, er), "R5 R8 pec from winner only", pec, ref_crc(8'h19, er));
                    check((won_cnt_a - wa0) == ((alert_a && addr_a == er) ? 1 : 0),
                          "R7 won pulse device a", 8'(won_cnt_a - wa0), (alert_a && addr_a == er) ? 8'h01 : 8'h00);
                    check((won_cnt_b - wb0) == ((alert_b && addr_b == er) ? 1 : 0),
                          "R7 won pulse device b", 8'(won_cnt_b - wb0), (alert_b && addr_b == er) ? 8'h01 : 8'h00);
                end
            end
        end

        // R7: clearing the winner exposes the next lowest alert
        addr_a = 8'h14; addr_b = 8'h08; alert_a = 1'b1; alert_b = 1'b1;
        query(acked, resp, pec);
        check(resp == 8'h08, "R7 first query lowest", resp, 8'h08);
        if (won_b) alert_b = 1'b0;
        if (won_cnt_b > 0) alert_b = 1'b0;
        query(acked, resp, pec);
        check(resp == 8'h14, "R7 second query after clear", resp, 8'h14);
        alert_a = 1'b0;
        query(acked, resp, pec);
        check(resp == 8'h19, "R4 R7 no alert left gives 0x19", resp, 8'h19);
        check(pec == ref_crc(8'h19, 8'h19), "R8 pec of idle reply", pec, ref_crc(8'h19, 8'h19));

        // R9: host NACK on the response byte, no PEC follows
        alert_a = 1'b1; addr_a = 8'h06;
        bus_start();
        write_byte(8'h19, acked);
        read_byte(1'b0, resp);
        check(resp == 8'h06, "R9 response before nack", resp, 8'h06);
        read_byte(1'b0, other);
        check(other == 8'hFF, "R9 no pec after nack", other, 8'hFF);
        bus_stop();

        // R1: repeated START after a rejected address is accepted
        bus_start();
        write_byte(8'h40, acked);
        check(!acked, "R1 rejected before repeated start", {7'd0, acked}, 8'h00);
        bus_start();
        write_byte(8'h19, acked);
        check(acked, "R1 repeated start accepted", {7'd0, acked}, 8'h01);
        read_byte(1'b1, resp);
        check(resp == 8'h06, "R1 response after repeated start", resp, 8'h06);
        bus_stop();
        repeat (4) @(negedge clk);
        check(oe_a == 1'b0 && oe_b == 1'b0, "R1 released after stop", {7'd0, oe_a | oe_b}, 8'h00);

        summary();
    end

endmodule